// File: doc/BRIEF.md
# Completion Ring Writer with Coalesced Write-Done Status

This block takes one-dword completion descriptors from an upstream producer and stores each of them into the next slot of a circular completion ring in host memory. It owns the producer index of that ring. Before it starts any store, it compares that index with the consumer index that the host publishes. A descriptor that would fill the last free slot is never written. The block drops it, leaves the index where it is, and raises a sticky error flag.

Each store is issued on a simple request/acknowledge port as a slot index plus data. The producer index moves forward, wrapping at the ring size, only when the store is acknowledged. Every acknowledged store counts toward a write-done flag. A 3-bit host code sets how many stores must complete before the flag is raised: every store, or a group of 2 to 128 stores. Both flags are sticky until the host clears them with a one-cycle clear pulse. Each flag can drive a shared interrupt line through its own enable.

Top module: `cmpl_ring_writer`

## Requirements
- R1: After reset, `wr_ptr` is 0, `sts_done`, `sts_err`, `irq` and `mem_req` are 0, and `desc_ready` is 1.
- R2: A descriptor is accepted when `desc_valid` and `desc_ready` are high on the same edge and the ring is not full. From the next cycle, `mem_req` is high with `mem_slot` equal to `wr_ptr` and `mem_data` equal to the descriptor. These stay stable until `mem_ack`, and `desc_ready` is low while the request is pending.
- R3: `wr_ptr` changes only on an edge where `mem_req` and `mem_ack` are both high. It then becomes (`wr_ptr`+1) modulo RING_DEPTH.
- R4: The ring is full when (`wr_ptr`+1) modulo RING_DEPTH equals `cfg_rd_ptr`. A descriptor offered while the ring is full is consumed and dropped. No request is issued, `wr_ptr` is unchanged, and `sts_err` is set.
- R5: With `cfg_coal_code` = 0, `sts_done` is set on every acknowledged store.
- R6: With `cfg_coal_code` = k in 1..7, `sts_done` is set on the acknowledged store that completes the 2^k-th store since reset or since the flag was last set. The store count then restarts at zero.
- R7: `sts_done` and `sts_err` stay set until a one-cycle pulse on `clr_done` or `clr_err`. A set and a clear on the same edge leave the flag set.
- R8: `irq` is high exactly when (`sts_done` and `cfg_done_irq_en`) or (`sts_err` and `cfg_err_irq_en`).
- R9: Dropped descriptors do not count toward the coalescing group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_data | input | DESC_W | Descriptor dword |
| mem_req | output | 1 | Ring store request |
| mem_slot | output | PTR_W | Ring slot index for the store |
| mem_data | output | DESC_W | Data for the store |
| mem_ack | input | 1 | Store accepted by memory |
| cfg_coal_code | input | COAL_W | Coalescing code: 0 means every store, k means 2^k stores |
| cfg_rd_ptr | input | PTR_W | Host consumer index |
| cfg_done_irq_en | input | 1 | Interrupt enable for write-done |
| cfg_err_irq_en | input | 1 | Interrupt enable for write-error |
| clr_done | input | 1 | Clear pulse for write-done |
| clr_err | input | 1 | Clear pulse for write-error |
| wr_ptr | output | PTR_W | Producer index |
| sts_done | output | 1 | Sticky write-done flag |
| sts_err | output | 1 | Sticky write-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The coalescing function is swept over all eight codes. A fresh reset precedes each code, and the bench checks `sts_done` after every store of a full group. This tells an off-by-one group size, or a wrong power-of-two decode, apart from a correct threshold. With the host index kept just behind the producer, the ring is filled to its last free slot and a further descriptor is offered. This separates a correct full test from one that allows an overflow or refuses one slot too early, and shows that the index wraps past the top slot. One drop is placed between two stores of a group of two, which shows whether dropped descriptors count. Clear pulses that coincide with a set, and all four interrupt enable combinations, complete the run.

// File: rtl/cmpl_ring_pkg.sv
package cmpl_ring_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

endpackage

// File: rtl/cmpl_ring_ptr.sv
module cmpl_ring_ptr #(
    parameter int RING_DEPTH = 16,
    localparam int PTR_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             full
);

    logic [PTR_W-1:0] wr_d, wr_q, ptr_inc;

    generate
        if ((RING_DEPTH & (RING_DEPTH - 1)) == 0) begin : g_pow2
            assign ptr_inc = wr_q + 1'b1;
        end else begin : g_any
            assign ptr_inc = (wr_q == PTR_W'(RING_DEPTH - 1)) ? '0 : wr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        wr_d = wr_q;
        if (advance) begin
            wr_d = ptr_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_ptr = wr_q;
    assign full   = (ptr_inc == rd_ptr);

endmodule

// File: rtl/cmpl_coalesce.sv
module cmpl_coalesce #(
    parameter int COAL_W = 3,
    localparam int CNT_W = 1 << COAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [COAL_W-1:0] code,
    output logic              hit
);

    logic [CNT_W-1:0] cnt_d, cnt_q, group;

    assign group = CNT_W'(1) << code;

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (wr_done) begin
            if (cnt_q + 1'b1 >= group) begin
                hit   = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cmpl_status.sv
module cmpl_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    input  logic en_done,
    input  logic en_err,
    output logic sts_done,
    output logic sts_err,
    output logic irq
);

    typedef struct packed {
        logic done;
        logic err;
    } flags_t;

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (clr_done) flg_d.done = 1'b0;
        if (clr_err)  flg_d.err  = 1'b0;
        if (set_done) flg_d.done = 1'b1;
        if (set_err)  flg_d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign sts_done = flg_q.done;
    assign sts_err  = flg_q.err;
    assign irq      = (flg_q.done && en_done) || (flg_q.err && en_err);

endmodule

// File: rtl/cmpl_ring_writer.sv
module cmpl_ring_writer
    import cmpl_ring_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    parameter int DESC_W     = 32,
    parameter int COAL_W     = 3,
    localparam int PTR_W     = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DESC_W-1:0] desc_data,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_slot,
    output logic [DESC_W-1:0] mem_data,
    input  logic              mem_ack,
    input  logic [COAL_W-1:0] cfg_coal_code,
    input  logic [PTR_W-1:0]  cfg_rd_ptr,
    input  logic              cfg_done_irq_en,
    input  logic              cfg_err_irq_en,
    input  logic              clr_done,
    input  logic              clr_err,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic              sts_done,
    output logic              sts_err,
    output logic              irq
);

    typedef struct packed {
        wr_state_e         state;
        logic [DESC_W-1:0] desc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ring_full;
    logic drop;
    logic wr_done;
    logic group_hit;

    always_comb begin
        ctl_d   = ctl_q;
        drop    = 1'b0;
        wr_done = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (desc_valid) begin
                    if (ring_full) begin
                        drop = 1'b1;
                    end else begin
                        ctl_d.state = ST_WRITE;
                        ctl_d.desc  = desc_data;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    wr_done     = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, desc: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign desc_ready = (ctl_q.state == ST_IDLE);
    assign mem_req    = (ctl_q.state == ST_WRITE);
    assign mem_data   = ctl_q.desc;
    assign mem_slot   = wr_ptr;

    cmpl_ring_ptr #(
        .RING_DEPTH(RING_DEPTH)
    ) i_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(wr_done),
        .rd_ptr (cfg_rd_ptr),
        .wr_ptr (wr_ptr),
        .full   (ring_full)
    );

    cmpl_coalesce #(
        .COAL_W(COAL_W)
    ) i_coal (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_done(wr_done),
        .code   (cfg_coal_code),
        .hit    (group_hit)
    );

    cmpl_status i_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_done(group_hit),
        .set_err (drop),
        .clr_done(clr_done),
        .clr_err (clr_err),
        .en_done (cfg_done_irq_en),
        .en_err  (cfg_err_irq_en),
        .sts_done(sts_done),
        .sts_err (sts_err),
        .irq     (irq)
    );

endmodule

// File: rtl/cmpl_ring_writer_chk.sv
module cmpl_ring_writer_chk #(
    parameter int RING_DEPTH = 16,
    parameter int DESC_W     = 32,
    localparam int PTR_W     = $clog2(RING_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic              mem_req,
    input logic [PTR_W-1:0]  mem_slot,
    input logic [DESC_W-1:0] mem_data,
    input logic              mem_ack,
    input logic [PTR_W-1:0]  cfg_rd_ptr,
    input logic              clr_err,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              sts_done,
    input logic              sts_err,
    input logic              irq
);

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (int'(p) == RING_DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_slot) && $stable(mem_data));

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !desc_ready);

    // R3
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> $past(mem_req && mem_ack));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> wr_ptr == step($past(wr_ptr)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready && (step(wr_ptr) == cfg_rd_ptr)
        |=> sts_err && !mem_req && $stable(wr_ptr));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_done) |-> $past(mem_req && mem_ack));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_err) |-> $past(clr_err));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_done && !sts_err |-> !irq);

endmodule

bind cmpl_ring_writer cmpl_ring_writer_chk #(
    .RING_DEPTH(RING_DEPTH),
    .DESC_W    (DESC_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_valid(desc_valid),
    .desc_ready(desc_ready),
    .mem_req   (mem_req),
    .mem_slot  (mem_slot),
    .mem_data  (mem_data),
    .mem_ack   (mem_ack),
    .cfg_rd_ptr(cfg_rd_ptr),
    .clr_err   (clr_err),
    .wr_ptr    (wr_ptr),
    .sts_done  (sts_done),
    .sts_err   (sts_err),
    .irq       (irq)
);

// File: tb/test_cmpl_ring_writer.sv
`timescale 1ns/1ps
module test_cmpl_ring_writer;

    localparam int DEPTH  = 8;
    localparam int DW     = 32;
    localparam int CW     = 3;
    localparam int PW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          desc_valid;
    logic          desc_ready;
    logic [DW-1:0] desc_data;
    logic          mem_req;
    logic [PW-1:0] mem_slot;
    logic [DW-1:0] mem_data;
    logic          mem_ack;
    logic [CW-1:0] cfg_coal_code;
    logic [PW-1:0] cfg_rd_ptr;
    logic          cfg_done_irq_en;
    logic          cfg_err_irq_en;
    logic          clr_done;
    logic          clr_err;
    logic [PW-1:0] wr_ptr;
    logic          sts_done;
    logic          sts_err;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;

    always #4 clk = ~clk;

    cmpl_ring_writer #(
        .RING_DEPTH(DEPTH),
        .DESC_W    (DW),
        .COAL_W    (CW)
    ) i_cmpl_ring_writer (
        .clk            (clk),
        .rst_n          (rst_n),
        .desc_valid     (desc_valid),
        .desc_ready     (desc_ready),
        .desc_data      (desc_data),
        .mem_req        (mem_req),
        .mem_slot       (mem_slot),
        .mem_data       (mem_data),
        .mem_ack        (mem_ack),
        .cfg_coal_code  (cfg_coal_code),
        .cfg_rd_ptr     (cfg_rd_ptr),
        .cfg_done_irq_en(cfg_done_irq_en),
        .cfg_err_irq_en (cfg_err_irq_en),
        .clr_done       (clr_done),
        .clr_err        (clr_err),
        .wr_ptr         (wr_ptr),
        .sts_done       (sts_done),
        .sts_err        (sts_err),
        .irq            (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        desc_valid = 1'b0;
        mem_ack = 1'b0;
        clr_done = 1'b0;
        clr_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_ptr = 0;
    endtask

    // Offer one descriptor; if accepted, hold the store for two cycles, then acknowledge it.
    task automatic offer(input logic [DW-1:0] d, input bit accept, input bit clr_with_ack);
        @(negedge clk);
        chk("R2 ready", desc_ready, 1);
        desc_valid = 1'b1;
        desc_data  = d;
        @(negedge clk);
        desc_valid = 1'b0;
        if (accept) begin
            chk("R2 req", mem_req, 1);
            chk("R2 slot", mem_slot, exp_ptr);
            chk("R2 data", mem_data, d);
            chk("R2 busy", desc_ready, 0);
            @(negedge clk);
            chk("R2 hold slot", mem_slot, exp_ptr);
            chk("R3 no move", wr_ptr, exp_ptr);
            mem_ack  = 1'b1;
            clr_done = clr_with_ack;
            @(negedge clk);
            mem_ack  = 1'b0;
            clr_done = 1'b0;
            exp_ptr  = (exp_ptr + 1) % DEPTH;
            chk("R3 advance", wr_ptr, exp_ptr);
            chk("R2 idle", mem_req, 0);
        end else begin
            chk("R4 no req", mem_req, 0);
            chk("R4 ptr held", wr_ptr, exp_ptr);
            chk("R4 err", sts_err, 1);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        desc_data       = '0;
        cfg_coal_code   = '0;
        cfg_rd_ptr      = '0;
        cfg_done_irq_en = 1'b0;
        cfg_err_irq_en  = 1'b0;
        do_reset();

        // R1 reset state
        chk("R1 ptr", wr_ptr, 0);
        chk("R1 done", sts_done, 0);
        chk("R1 err", sts_err, 0);
        chk("R1 req", mem_req, 0);
        chk("R1 ready", desc_ready, 1);
        chk("R1 irq", irq, 0);

        // R5 / R6 sweep over every coalescing code; host index tracks the producer
        for (int code = 0; code < 8; code++) begin
            cfg_coal_code = CW'(code);
            do_reset();
            for (int n = 1; n <= (1 << code); n++) begin
                cfg_rd_ptr = PW'(exp_ptr);
                offer(DW'(32'hA500_0000 + (code << 8) + n), 1'b1, 1'b0);
                if (code == 0) chk("R5 every store", sts_done, 1);
                else chk("R6 group", sts_done, (n == (1 << code)) ? 1 : 0);
            end
            // counter restarted: after clearing, one more group is needed again
            @(negedge clk); clr_done = 1'b1;
            @(negedge clk); clr_done = 1'b0;
            chk("R7 clear", sts_done, 0);
            if (code > 0) begin
                cfg_rd_ptr = PW'(exp_ptr);
                offer(DW'(32'h5A00_0000 + code), 1'b1, 1'b0);
                chk("R6 restart", sts_done, 0);
            end
        end

        // R4 fill to last free slot, then overflow, then wrap
        cfg_coal_code = '0;
        do_reset();
        cfg_rd_ptr = '0;
        for (int n = 0; n < DEPTH - 1; n++) offer(DW'(32'hF000 + n), 1'b1, 1'b0);
        chk("R4 before full err", sts_err, 0);
        offer(DW'(32'hDEAD), 1'b0, 1'b0);
        chk("R4 ptr at top", wr_ptr, DEPTH - 1);
        cfg_rd_ptr = PW'(3);
        offer(DW'(32'hBEEF), 1'b1, 1'b0);
        chk("R3 wrap", wr_ptr, 0);
        chk("R7 err sticky", sts_err, 1);

        // R8 interrupt enables (both flags set here)
        cfg_done_irq_en = 1'b0; cfg_err_irq_en = 1'b0; #1;
        chk("R8 none", irq, 0);
        cfg_done_irq_en = 1'b1; #1;
        chk("R8 done", irq, 1);
        cfg_done_irq_en = 1'b0; cfg_err_irq_en = 1'b1; #1;
        chk("R8 err", irq, 1);
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        chk("R7 err clear", sts_err, 0);
        chk("R8 err cleared", irq, 0);
        cfg_err_irq_en = 1'b0;

        // R7 set and clear on the same edge: flag stays set
        cfg_rd_ptr = PW'(exp_ptr);
        offer(DW'(32'h77), 1'b1, 1'b1);
        chk("R7 set wins", sts_done, 1);

        // R9 a dropped descriptor does not count toward a group of two
        cfg_coal_code = CW'(1);
        do_reset();
        cfg_rd_ptr = PW'(2);
        offer(DW'(32'h1), 1'b1, 1'b0);
        chk("R9 first", sts_done, 0);
        offer(DW'(32'h2), 1'b0, 1'b0);
        chk("R9 drop not counted", sts_done, 0);
        cfg_rd_ptr = PW'(5);
        offer(DW'(32'h3), 1'b1, 1'b0);
        chk("R9 second store", sts_done, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule